// File: doc/BRIEF.md
# Keyed Configuration Byte-Stream Port

This block holds a small table of variable-length byte items for boot firmware to read, and a few items that firmware may fill. The host sees two ports. A 16-bit control port takes a key that names one item. A byte-wide data port then moves that item's bytes one per access. A byte cursor steps forward on its own after each accepted access. The items sit in two banks, a generic one and an architecture-local one. Fixed items carry a signature and integer values stored lowest byte first. Writable items raise a one-cycle completion strobe, tagged with the item's bank and index, once their last byte is written.

Host accesses arrive one per cycle as a valid strobe with a port select, a direction and a size. Read data is registered: it appears on `rd_data` in the cycle after the read access and holds until the next read. The item table is computed from the project package. Reset reloads it, so bytes written by firmware last until the next reset.

Top module: `cfg_stream_port`

## Requirements
- R1: After a synchronous active-low reset the selection is key 0 at byte 0, `rd_data` and `done_stb` are 0, and every item holds its initial contents again.
- R2: A 16-bit write to the control port stores the key and sets the byte cursor to 0, for valid and invalid keys alike, including in the middle of an item.
- R3: Key bit 15 set selects the architecture-local bank and clear selects the generic bank. Bits 13:0 give the item index. An index of NUM_ITEMS or more marks the selection invalid, and data reads then return 0x00.
- R4: A byte read of the data port with a valid selection and the cursor below the item length returns the byte at the cursor and advances the cursor by one. With the cursor at or past the length it returns 0x00 and leaves the cursor unchanged.
- R5: An item of length zero has no storage, and every data read of it returns 0x00.
- R6: A byte write to the data port is accepted only when key bit 14 is set, the selection is valid and the cursor is below the item length. An accepted write stores the byte at the cursor and advances the cursor. Any other data write changes neither contents nor cursor.
- R7: The accepted write that brings the cursor up to the item length pulses `done_stb` for one cycle in the following cycle, with `done_bank` and `done_idx` naming the item, and returns the cursor to 0.
- R8: Generic item 0 holds the 4-byte signature 0x43 0x46 0x47 0x30. Generic items 1, 2 and 3 hold 0x1234, 0xA1B2C3D4 and 0x0123456789ABCDEF, and local item 0 holds 0x5AA5, each with the least significant byte first.
- R9: Byte writes to the control port and 16-bit accesses to the data port are ignored, leaving key, cursor and contents unchanged. A 16-bit data read and any control-port read return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | One host access in this cycle |
| bus_sel | input | 1 | 0 = control port, 1 = data port |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data (key, or byte in bits 7:0) |
| rd_data | output | 8 | Registered read data |
| done_stb | output | 1 | One-cycle completion pulse for a filled writable item |
| done_bank | output | 1 | Bank of the completed item (1 = local) |
| done_idx | output | 3 | Index of the completed item |

## Verification
The final write into a writable item does three things in one cycle. It stores the last byte, it raises the completion pulse, and it moves the cursor back to 0. A cursor left unwrapped or a store that is dropped could hide behind a correct pulse. The bench fills a 3-byte item and then writes one more byte without reselecting. It expects the pulse only in the cycle after the third write, and the fourth byte must overwrite byte 0. A fresh read of the item must show the fourth byte followed by the second and third bytes, which tests all three actions of that one cycle together.

// File: rtl/cfg_stream_pkg.sv
// Package: shared constants and the initial item table of the configuration
// port. Item contents are computed here, not listed, so the table follows
// its value definitions. Assumes items are at most 8 bytes of integer data.
package cfg_stream_pkg;

    localparam int BANKS = 2;

    // Length in bytes of item i of bank b (b = 1 is the local bank).
    function automatic logic [15:0] item_len(input int b, input int i);
        logic [15:0] l;
        l = 16'd0;
        if (b == 0) begin
            case (i)
                0:       l = 16'd4;   // signature
                1:       l = 16'd2;   // 16-bit integer
                2:       l = 16'd4;   // 32-bit integer
                3:       l = 16'd8;   // 64-bit integer
                5:       l = 16'd3;   // writable buffer
                default: l = 16'd0;
            endcase
        end else begin
            case (i)
                0:       l = 16'd2;   // 16-bit integer
                1:       l = 16'd4;   // writable buffer
                default: l = 16'd0;
            endcase
        end
        return l;
    endfunction

    // Integer image of an item; byte k is taken least significant first.
    function automatic logic [63:0] item_value(input int b, input int i);
        logic [63:0] v;
        v = 64'd0;
        if (b == 0) begin
            case (i)
                0:       v = 64'h0000_0000_3047_4643;
                1:       v = 64'h0000_0000_0000_1234;
                2:       v = 64'h0000_0000_A1B2_C3D4;
                3:       v = 64'h0123_4567_89AB_CDEF;
                default: v = 64'd0;
            endcase
        end else if (i == 0) begin
            v = 64'h0000_0000_0000_5AA5;
        end
        return v;
    endfunction

    // Initial byte k of item i in bank b.
    function automatic logic [7:0] item_byte(input int b, input int i, input int k);
        logic [63:0] s;
        s = 64'd0;
        if (k < 8) begin
            s = item_value(b, i) >> (8 * k);
        end
        return s[7:0];
    endfunction

endpackage

// File: rtl/cfg_key_decode.sv
// Module: splits a selection key into bank, write-channel flag and item index
// and flags indices outside the table. Purely combinational.
// Assumes the bank flag is the top key bit and the write flag the next one.
module cfg_key_decode #(
    parameter int KEY_W     = 16,
    parameter int NUM_ITEMS = 8,
    parameter int IDX_W     = $clog2(NUM_ITEMS)
) (
    input  logic [KEY_W-1:0] key,
    output logic             bank_local,
    output logic             wr_chan,
    output logic [IDX_W-1:0] idx,
    output logic             sel_ok
);
    localparam int FIELD_W = KEY_W - 2;

    logic [FIELD_W-1:0] field;

    // Field extraction and range test of the item index.
    always_comb begin
        bank_local = key[KEY_W-1];
        wr_chan    = key[KEY_W-2];
        field      = key[FIELD_W-1:0];
        sel_ok     = (field < FIELD_W'(NUM_ITEMS));
        idx        = field[IDX_W-1:0];
    end
endmodule

// File: rtl/cfg_item_store.sv
// Module: byte storage for both banks with per-item lengths. Reset reloads
// the initial table from the package. One read address and one write port
// share the current bank/index/offset. Assumes table lengths fit MAX_LEN;
// larger lengths are clamped.
module cfg_item_store
    import cfg_stream_pkg::*;
#(
    parameter int NUM_ITEMS = 8,
    parameter int MAX_LEN   = 8,
    parameter int LEN_W     = 16,
    parameter int IDX_W     = $clog2(NUM_ITEMS),
    parameter int OFF_W     = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bank,
    input  logic [IDX_W-1:0] idx,
    input  logic [OFF_W-1:0] off,
    input  logic             wr_en,
    input  logic [7:0]       wr_byte,
    output logic [7:0]       rd_byte,
    output logic [LEN_W-1:0] len
);
    logic [7:0] mem [BANKS][NUM_ITEMS][MAX_LEN];
    logic [15:0] raw_len;

    // Table reload on reset, single byte update on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BANKS; b++) begin
                for (int i = 0; i < NUM_ITEMS; i++) begin
                    for (int k = 0; k < MAX_LEN; k++) begin
                        mem[b][i][k] <= item_byte(b, i, k);
                    end
                end
            end
        end else if (wr_en) begin
            mem[bank][idx][off] <= wr_byte;
        end
    end

    // Byte and length lookup for the current selection.
    always_comb begin
        rd_byte = mem[bank][idx][off];
        raw_len = item_len(int'(bank), int'(idx));
        if (LEN_W'(raw_len) > LEN_W'(MAX_LEN)) begin
            len = LEN_W'(MAX_LEN);
        end else begin
            len = LEN_W'(raw_len);
        end
    end
endmodule

// File: rtl/cfg_cursor.sv
// Module: holds the selected key and byte cursor, decides whether data
// accesses hit, and raises the completion pulse. Assumes at most one access
// per cycle and that the caller has already classified it.
module cfg_cursor #(
    parameter int KEY_W = 16,
    parameter int LEN_W = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [KEY_W-1:0] new_key,
    input  logic             data_rd,
    input  logic             data_wr,
    input  logic             sel_ok,
    input  logic             wr_chan,
    input  logic             bank,
    input  logic [IDX_W-1:0] idx,
    input  logic [LEN_W-1:0] item_len,
    output logic [KEY_W-1:0] cur_key,
    output logic [LEN_W-1:0] cur_off,
    output logic             rd_hit,
    output logic             wr_take,
    output logic             done_stb,
    output logic             done_bank,
    output logic [IDX_W-1:0] done_idx
);
    logic [LEN_W-1:0] off_inc;
    logic             last_byte;

    // Hit decisions for the pending data access.
    always_comb begin
        off_inc   = cur_off + LEN_W'(1);
        rd_hit    = sel_ok && (cur_off < item_len);
        wr_take   = data_wr && sel_ok && wr_chan && (cur_off < item_len);
        last_byte = (off_inc == item_len);
    end

    // Key and cursor update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_key <= '0;
            cur_off <= '0;
        end else if (sel_wr) begin
            cur_key <= new_key;
            cur_off <= '0;
        end else if (data_rd && rd_hit) begin
            cur_off <= off_inc;
        end else if (wr_take) begin
            cur_off <= last_byte ? '0 : off_inc;
        end
    end

    // Completion pulse with the item identity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_stb  <= 1'b0;
            done_bank <= 1'b0;
            done_idx  <= '0;
        end else begin
            done_stb <= wr_take && last_byte;
            if (wr_take && last_byte) begin
                done_bank <= bank;
                done_idx  <= idx;
            end
        end
    end
endmodule

// File: rtl/cfg_stream_port.sv
// Module: top of the keyed configuration byte-stream port. Classifies each
// host access, ties key decode, cursor and storage together and registers
// read data. Assumes one access per cycle; unsupported sizes are ignored.
module cfg_stream_port #(
    parameter int KEY_W     = 16,
    parameter int NUM_ITEMS = 8,
    parameter int MAX_LEN   = 8,
    parameter int LEN_W     = 16,
    parameter int IDX_W     = $clog2(NUM_ITEMS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic             bus_word,
    input  logic [KEY_W-1:0] bus_wdata,
    output logic [7:0]       rd_data,
    output logic             done_stb,
    output logic             done_bank,
    output logic [IDX_W-1:0] done_idx
);
    localparam int OFF_W = $clog2(MAX_LEN);

    logic             sel_wr, data_rd, data_wr, any_rd;
    logic [KEY_W-1:0] cur_key;
    logic [LEN_W-1:0] cur_off;
    logic             bank_local, wr_chan, sel_ok;
    logic [IDX_W-1:0] idx;
    logic             rd_hit, wr_take;
    logic [7:0]       rd_byte;
    logic [LEN_W-1:0] item_len;

    // Access classification.
    always_comb begin
        sel_wr  = bus_valid && !bus_sel && bus_we && bus_word;
        data_rd = bus_valid && bus_sel && !bus_we && !bus_word;
        data_wr = bus_valid && bus_sel && bus_we && !bus_word;
        any_rd  = bus_valid && !bus_we;
    end

    cfg_key_decode #(.KEY_W(KEY_W), .NUM_ITEMS(NUM_ITEMS), .IDX_W(IDX_W)) u_dec (
        .key        (cur_key),
        .bank_local (bank_local),
        .wr_chan    (wr_chan),
        .idx        (idx),
        .sel_ok     (sel_ok)
    );

    cfg_cursor #(.KEY_W(KEY_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_cur (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .new_key   (bus_wdata),
        .data_rd   (data_rd),
        .data_wr   (data_wr),
        .sel_ok    (sel_ok),
        .wr_chan   (wr_chan),
        .bank      (bank_local),
        .idx       (idx),
        .item_len  (item_len),
        .cur_key   (cur_key),
        .cur_off   (cur_off),
        .rd_hit    (rd_hit),
        .wr_take   (wr_take),
        .done_stb  (done_stb),
        .done_bank (done_bank),
        .done_idx  (done_idx)
    );

    cfg_item_store #(
        .NUM_ITEMS (NUM_ITEMS),
        .MAX_LEN   (MAX_LEN),
        .LEN_W     (LEN_W),
        .IDX_W     (IDX_W),
        .OFF_W     (OFF_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank    (bank_local),
        .idx     (idx),
        .off     (cur_off[OFF_W-1:0]),
        .wr_en   (wr_take),
        .wr_byte (bus_wdata[7:0]),
        .rd_byte (rd_byte),
        .len     (item_len)
    );

    // Registered read data: item byte on a hit, zero for every other read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
        end else if (any_rd) begin
            rd_data <= (data_rd && rd_hit) ? rd_byte : 8'h00;
        end
    end
endmodule

// File: rtl/cfg_stream_port_chk.sv
// Module: temporal checks on the configuration port, bound to the top.
module cfg_stream_port_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_sel,
    input logic             bus_we,
    input logic             bus_word,
    input logic [7:0]       rd_data,
    input logic             done_stb,
    input logic [LEN_W-1:0] cur_off,
    input logic             rd_hit
);
    // R7
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |-> $past(bus_valid && bus_sel && bus_we && !bus_word));

    // R2
    select_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_sel && bus_we && bus_word) |=> (cur_off == '0));

    // R4
    miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_sel && !bus_we && !bus_word && !rd_hit)
        |=> (rd_data == 8'h00 && $stable(cur_off)));

    // R4
    hit_read_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_sel && !bus_we && !bus_word && rd_hit)
        |=> (cur_off == $past(cur_off) + LEN_W'(1)));

    // R9
    ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_sel && !bus_we) |=> (rd_data == 8'h00));

    // R9
    data_word_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_sel && bus_word) |=> $stable(cur_off));
endmodule

bind cfg_stream_port cfg_stream_port_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_word  (bus_word),
    .rd_data   (rd_data),
    .done_stb  (done_stb),
    .cur_off   (cur_off),
    .rd_hit    (rd_hit)
);

// File: tb/cfg_stream_port_tb.sv
`timescale 1ns/1ps
module cfg_stream_port_tb;
    // vector layout: [32] we [31] sel [30] word [29:14] data [13:6] exp
    //                [5] check rd [4] exp done [3:0] requirement
    typedef logic [32:0] vec_t;

    function automatic vec_t mk(input logic we, input logic sel, input logic word,
                                input logic [15:0] d, input logic [7:0] e,
                                input logic c, input logic dn, input logic [3:0] r);
        return {we, sel, word, d, e, c, dn, r};
    endfunction
    function automatic vec_t CTL(input logic [15:0] k, input logic [3:0] r);
        return mk(1'b1, 1'b0, 1'b1, k, 8'h00, 1'b0, 1'b0, r);
    endfunction
    function automatic vec_t RD(input logic [7:0] e, input logic [3:0] r);
        return mk(1'b0, 1'b1, 1'b0, 16'h0, e, 1'b1, 1'b0, r);
    endfunction
    function automatic vec_t WR(input logic [7:0] b, input logic dn, input logic [3:0] r);
        return mk(1'b1, 1'b1, 1'b0, {8'h00, b}, 8'h00, 1'b0, dn, r);
    endfunction

    localparam int NV = 51;
    localparam vec_t VEC [NV] = '{
        RD(8'h43, 4'd1), RD(8'h46, 4'd1),                    // R1 reset key 0
        RD(8'h47, 4'd8), RD(8'h30, 4'd8),                    // R8 signature
        RD(8'h00, 4'd4), RD(8'h00, 4'd4),                    // R4 past end
        CTL(16'h0001, 4'd2), RD(8'h34, 4'd8), RD(8'h12, 4'd8), RD(8'h00, 4'd4), // R8
        CTL(16'h0002, 4'd2), RD(8'hD4, 4'd8), RD(8'hC3, 4'd8),
        RD(8'hB2, 4'd8), RD(8'hA1, 4'd8),
        CTL(16'h0003, 4'd2), RD(8'hEF, 4'd8), RD(8'hCD, 4'd8),
        CTL(16'h0003, 4'd2), RD(8'hEF, 4'd2),                // R2 mid-item reselect
        CTL(16'h0004, 4'd5), RD(8'h00, 4'd5),                // R5 empty item
        CTL(16'h0009, 4'd3), RD(8'h00, 4'd3),                // R3 invalid index
        CTL(16'h4008, 4'd3), WR(8'h77, 1'b0, 4'd3),          // R3 invalid write
        CTL(16'h8000, 4'd3), RD(8'hA5, 4'd3), RD(8'h5A, 4'd3), // R3 local bank
        CTL(16'h0005, 4'd6), WR(8'h11, 1'b0, 4'd6), RD(8'h00, 4'd6), // R6 no write bit
        CTL(16'h4005, 4'd7), WR(8'hAA, 1'b0, 4'd7), WR(8'hBB, 1'b0, 4'd7),
        WR(8'hCC, 1'b1, 4'd7), WR(8'hDD, 1'b0, 4'd7),        // R7 pulse and wrap
        CTL(16'h0005, 4'd7), RD(8'hDD, 4'd7), RD(8'hBB, 4'd7),
        RD(8'hCC, 4'd7), RD(8'h00, 4'd7),
        CTL(16'h0001, 4'd9),
        mk(1'b1, 1'b0, 1'b0, 16'h0002, 8'h00, 1'b0, 1'b0, 4'd9), // R9 byte ctl write
        RD(8'h34, 4'd9),
        mk(1'b0, 1'b1, 1'b1, 16'h0000, 8'h00, 1'b1, 1'b0, 4'd9), // R9 word data read
        RD(8'h12, 4'd9),
        mk(1'b0, 1'b0, 1'b1, 16'h0000, 8'h00, 1'b1, 1'b0, 4'd9), // R9 ctl read
        CTL(16'h4005, 4'd9),
        mk(1'b1, 1'b1, 1'b1, 16'h0055, 8'h00, 1'b0, 1'b0, 4'd9), // R9 word data write
        RD(8'hDD, 4'd9)
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0, bus_sel = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0] rd_data;
    logic       done_stb, done_bank;
    logic [2:0] done_idx;
    int         checks = 0, errors = 0;
    logic       finished = 1'b0;

    always #2 clk = ~clk;

    cfg_stream_port u_dut (
        .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid), .bus_sel (bus_sel),
        .bus_we (bus_we), .bus_word (bus_word), .bus_wdata (bus_wdata),
        .rd_data (rd_data), .done_stb (done_stb), .done_bank (done_bank),
        .done_idx (done_idx)
    );

    task automatic check(input int r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    // Drives one access at a falling edge; returns at the next falling edge.
    task automatic access(input logic we, input logic sel, input logic word,
                          input logic [15:0] d);
        bus_valid = 1'b1; bus_we = we; bus_sel = sel; bus_word = word; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check(1, "reset rd_data", int'(rd_data), 0);      // R1
        check(1, "reset done_stb", int'(done_stb), 0);    // R1

        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VEC[v];
            access(t[32], t[31], t[30], t[29:14]);
            if (t[5]) check(int'(t[3:0]), $sformatf("vec %0d rd_data", v),
                            int'(rd_data), int'(t[13:6]));
            check(int'(t[3:0]), $sformatf("vec %0d done_stb", v),
                  int'(done_stb), int'(t[4]));
        end

        // R7 local writable item: pulse identity and stored bytes
        access(1'b1, 1'b0, 1'b1, 16'hC001);
        for (int k = 1; k <= 4; k++) begin
            access(1'b1, 1'b1, 1'b0, 16'(k));
            check(7, $sformatf("local write %0d done", k), int'(done_stb), (k == 4) ? 1 : 0);
        end
        check(7, "done_bank", int'(done_bank), 1);
        check(7, "done_idx", int'(done_idx), 1);
        access(1'b1, 1'b0, 1'b1, 16'h8001);
        for (int k = 1; k <= 4; k++) begin
            access(1'b0, 1'b1, 1'b0, 16'h0);
            check(6, $sformatf("local readback %0d", k), int'(rd_data), k);
        end

        // R1 reset mid-stream restores key 0 and the written item contents
        access(1'b1, 1'b0, 1'b1, 16'h0002);
        access(1'b0, 1'b1, 1'b0, 16'h0);
        do_reset();
        access(1'b0, 1'b1, 1'b0, 16'h0);
        check(1, "post-reset key 0 byte 0", int'(rd_data), 'h43);
        access(1'b1, 1'b0, 1'b1, 16'h0005);
        access(1'b0, 1'b1, 1'b0, 16'h0);
        check(1, "post-reset table reload", int'(rd_data), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule